// File: doc/BRIEF.md
# Shared Column-Tree 4-bit Multiply/Add Unit

This block is a purely combinational unsigned arithmetic unit for two 4-bit operands. In multiply mode it forms every single-bit AND product of the two operands and gathers them by output weight, so that each column holds the products whose bit indices add up to that weight. A chain of column adders then reduces the columns to an 8-bit product. Each column sums its own terms plus the carry from the column below and passes its carry upward.

The same column chain also serves 4-bit addition and subtraction. In those modes a steering stage feeds the low columns with the first operand and with an XOR-conditioned copy of the second operand, and it sets the chain's carry-in for two's-complement subtraction. A 2-bit operation select chooses the mode. There is no state, so the result follows the inputs after the combinational delay.

Top module: `vcm_arith_unit`

## Requirements
- R1: With `op_sel` = 2'b00 (multiply), `result` equals `op_a * op_b` as an unsigned 8-bit value for all 256 operand pairs.
- R2: In multiply mode, `result[0]` equals `op_a[0] & op_b[0]`.
- R3: In multiply mode, the largest product 15 * 15 = 225 (8'hE1) appears in full, including bit 7.
- R4: With `op_sel` = 2'b01 (add), `result[3:0]` is `(op_a + op_b) mod 16`, `result[4]` is the carry-out, and `result[7:5]` are zero.
- R5: In add mode, `carry_flag` is 1 exactly when `op_a + op_b` exceeds 15.
- R6: With `op_sel` = 2'b10 (subtract), `result[3:0]` is `(op_a - op_b) mod 16`, `result[4]` and `carry_flag` are 1 exactly when `op_a >= op_b` (no borrow), and `result[7:5]` are zero.
- R7: With `op_sel` = 2'b11 (reserved), `result` is 8'h00 and `carry_flag` is 0 for every operand pair.
- R8: In multiply mode, `carry_flag` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 4 | First unsigned operand |
| op_b | input | 4 | Second unsigned operand (subtrahend in subtract mode) |
| op_sel | input | 2 | 00 multiply, 01 add, 10 subtract, 11 reserved |
| result | output | 8 | Product, or zero-extended sum/difference with the carry in bit 4 |
| carry_flag | output | 1 | Carry-out in add mode, no-borrow in subtract mode, 0 otherwise |

## Verification
The hardest case to reach is a carry that ripples through every column of the chain at once. In multiply mode that happens only for operand pairs near 15 * 15, where the dense middle columns overflow into bit 7. In subtract mode it happens when the XOR-inverted subtrahend plus the carry-in wraps through all four low columns, as with equal operands. Random stimulus could miss these pairs, so the stimulus sweeps all 256 operand pairs under each of the four select codes. Every path through the shared chain is therefore exercised, including each borrow boundary.

// File: rtl/vcm_pkg.sv
package vcm_pkg;
  typedef enum logic [1:0] {
    VCM_MUL  = 2'b00,
    VCM_ADD  = 2'b01,
    VCM_SUB  = 2'b10,
    VCM_RSVD = 2'b11
  } vcm_op_e;
endpackage

// File: rtl/vcm_cross_terms.sv
// AND-matrix partial products, grouped by output weight (crosswise diagonals).
module vcm_cross_terms #(
  parameter int W = 4,
  localparam int COLS = 2*W - 1
) (
  input  logic [W-1:0]              mul_a,
  input  logic [W-1:0]              mul_b,
  output logic [COLS-1:0][W-1:0]    col_terms
);
  for (genvar k = 0; k < COLS; k++) begin : g_col
    for (genvar j = 0; j < W; j++) begin : g_term
      if ((k - j) >= 0 && (k - j) < W) begin : g_live
        assign col_terms[k][j] = mul_a[j] & mul_b[k-j];
      end else begin : g_empty
        assign col_terms[k][j] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/vcm_addsub_terms.sv
// Places operand bits into the low columns; subtrahend is XOR-conditioned.
module vcm_addsub_terms #(
  parameter int W = 4,
  localparam int COLS = 2*W - 1
) (
  input  logic [W-1:0]              add_a,
  input  logic [W-1:0]              add_b,
  input  logic                      invert_b,
  output logic [COLS-1:0][W-1:0]    col_terms,
  output logic                      tree_cin
);
  logic [W-1:0] b_cond;
  assign b_cond   = add_b ^ {W{invert_b}};
  assign tree_cin = invert_b;

  for (genvar k = 0; k < COLS; k++) begin : g_col
    for (genvar j = 0; j < W; j++) begin : g_term
      if (k < W && j == 0) begin : g_opa
        assign col_terms[k][j] = add_a[k];
      end else if (k < W && j == 1) begin : g_opb
        assign col_terms[k][j] = b_cond[k];
      end else begin : g_empty
        assign col_terms[k][j] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/vcm_column_tree.sv
// Column-by-column reduction: each column adds its terms and the incoming carry.
module vcm_column_tree #(
  parameter int W = 4,
  localparam int COLS = 2*W - 1,
  localparam int RW   = 2*W,
  localparam int CW   = $clog2(2*W + 2) + 1
) (
  input  logic [COLS-1:0][W-1:0]    col_terms,
  input  logic                      tree_cin,
  output logic [RW-1:0]             tree_sum
);
  logic [COLS:0][CW-1:0] carry_chain;
  logic [COLS-1:0][CW-1:0] col_total;

  assign carry_chain[0] = {{(CW-1){1'b0}}, tree_cin};

  for (genvar k = 0; k < COLS; k++) begin : g_col
    always_comb begin
      col_total[k] = carry_chain[k];
      for (int t = 0; t < W; t++) begin
        col_total[k] = col_total[k] + {{(CW-1){1'b0}}, col_terms[k][t]};
      end
    end
    assign tree_sum[k]      = col_total[k][0];
    assign carry_chain[k+1] = {1'b0, col_total[k][CW-1:1]};
  end

  assign tree_sum[RW-1] = carry_chain[COLS][0];
endmodule

// File: rtl/vcm_arith_unit.sv
module vcm_arith_unit #(
  parameter int W = 4,
  localparam int COLS = 2*W - 1,
  localparam int RW   = 2*W
) (
  input  logic [W-1:0]  op_a,
  input  logic [W-1:0]  op_b,
  input  logic [1:0]    op_sel,
  output logic [RW-1:0] result,
  output logic          carry_flag
);
  import vcm_pkg::*;

  vcm_op_e                 op;
  logic [COLS-1:0][W-1:0]  mul_cols;
  logic [COLS-1:0][W-1:0]  as_cols;
  logic [COLS-1:0][W-1:0]  sel_cols;
  logic                    as_cin;
  logic                    sel_cin;
  logic [RW-1:0]           tree_sum;

  assign op = vcm_op_e'(op_sel);

  vcm_cross_terms #(.W(W)) u_cross (
    .mul_a     (op_a),
    .mul_b     (op_b),
    .col_terms (mul_cols)
  );

  vcm_addsub_terms #(.W(W)) u_addsub (
    .add_a     (op_a),
    .add_b     (op_b),
    .invert_b  (op == VCM_SUB),
    .col_terms (as_cols),
    .tree_cin  (as_cin)
  );

  always_comb begin
    sel_cols = '0;
    sel_cin  = 1'b0;
    unique case (op)
      VCM_MUL:          begin sel_cols = mul_cols; sel_cin = 1'b0;   end
      VCM_ADD, VCM_SUB: begin sel_cols = as_cols;  sel_cin = as_cin; end
      default:          begin sel_cols = '0;       sel_cin = 1'b0;   end
    endcase
  end

  vcm_column_tree #(.W(W)) u_tree (
    .col_terms (sel_cols),
    .tree_cin  (sel_cin),
    .tree_sum  (tree_sum)
  );

  always_comb begin
    result     = tree_sum;
    carry_flag = 1'b0;
    if (op == VCM_ADD || op == VCM_SUB) begin
      carry_flag = tree_sum[W];
    end else if (op == VCM_RSVD) begin
      result = '0;
    end
  end
endmodule

// File: rtl/vcm_arith_checker.sv
module vcm_arith_checker #(
  parameter int W = 4
) (
  input logic [W-1:0]   op_a,
  input logic [W-1:0]   op_b,
  input logic [1:0]     op_sel,
  input logic [2*W-1:0] result,
  input logic           carry_flag
);
  logic [2*W-1:0] ref_mul;
  logic [W:0]     ref_add;
  logic [W-1:0]   ref_dif;
  logic           known;

  always_comb begin
    known   = !$isunknown({op_a, op_b, op_sel, result, carry_flag});
    ref_mul = (2*W)'(op_a) * (2*W)'(op_b);
    ref_add = (W+1)'(op_a) + (W+1)'(op_b);
    ref_dif = op_a - op_b;
    if (known) begin
      // R1
      mul_product_chk: assert (op_sel != 2'b00 || result == ref_mul);
      // R8
      mul_flag_low_chk: assert (op_sel != 2'b00 || carry_flag == 1'b0);
      // R4
      add_sum_chk: assert (op_sel != 2'b01 || result == (2*W)'(ref_add));
      // R5
      add_carry_chk: assert (op_sel != 2'b01 || carry_flag == ref_add[W]);
      // R6
      sub_diff_chk: assert (op_sel != 2'b10 ||
                            (result[W-1:0] == ref_dif && carry_flag == (op_a >= op_b)
                             && result[W] == carry_flag));
      // R7
      rsvd_quiet_chk: assert (op_sel != 2'b11 || (result == '0 && !carry_flag));
    end
  end
endmodule

bind vcm_arith_unit vcm_arith_checker #(.W(W)) u_chk (
  .op_a       (op_a),
  .op_b       (op_b),
  .op_sel     (op_sel),
  .result     (result),
  .carry_flag (carry_flag)
);

// File: tb/vcm_arith_unit_test.sv
module vcm_arith_unit_test;
  logic       clk;
  logic       rst_n;
  logic [3:0] a;
  logic [3:0] b;
  logic [1:0] sel;
  logic [7:0] result;
  logic       carry_flag;

  typedef struct {
    logic [1:0] op;
    logic [7:0] exp_res;
    logic       exp_flag;
    logic       a0b0;
    string      rtag;
    string      ftag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  vcm_arith_unit uut (
    .op_a(a), .op_b(b), .op_sel(sel), .result(result), .carry_flag(carry_flag)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (a=%0d b=%0d sel=%0d)", tag, act, exp, a, b, sel);
    end
  endtask

  task automatic drive(input int x, input int y, input int o);
    item_t it;
    int sum;
    @(posedge clk);
    a   = 4'(x);
    b   = 4'(y);
    sel = 2'(o);
    it.op   = 2'(o);
    it.a0b0 = 1'(x & y & 1);
    case (o)
      0: begin
        it.exp_res  = 8'(x * y);
        it.exp_flag = 1'b0;
        it.rtag = (x == 15 && y == 15) ? "R3" : "R1";
        it.ftag = "R8";
      end
      1: begin
        sum = x + y;
        it.exp_res  = 8'(sum);
        it.exp_flag = (sum > 15);
        it.rtag = "R4";
        it.ftag = "R5";
      end
      2: begin
        it.exp_flag = (x >= y);
        it.exp_res  = {3'b000, it.exp_flag, 4'(x - y)};
        it.rtag = "R6";
        it.ftag = "R6";
      end
      default: begin
        it.exp_res  = 8'h00;
        it.exp_flag = 1'b0;
        it.rtag = "R7";
        it.ftag = "R7";
      end
    endcase
    q.push_back(it);
  endtask

  // monitor: pops expected items half a cycle after they are driven
  always @(negedge clk) begin
    if (rst_n && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check(it.rtag, int'(result), int'(it.exp_res));
      check(it.ftag, int'(carry_flag), int'(it.exp_flag));
      if (it.op == 2'b00) check("R2", int'(result[0]), int'(it.a0b0));
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 20000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    a = 4'd0; b = 4'd0; sel = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", int'(result), 0);
    check("R8", int'(carry_flag), 0);
    rst_n = 1'b1;
    for (int o = 0; o < 4; o++)
      for (int x = 0; x < 16; x++)
        for (int y = 0; y < 16; y++)
          drive(x, y, o);
    while (q.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule